// File: doc/BRIEF.md
# Asynchronous Handshaked 16-bit Bus Master

This block turns single requests from an internal port into cycles on an external bus. That bus has a 16-bit data path and ends each cycle on an acknowledge. A request carries a 32-bit byte address, a size (byte, word or long word), a direction and write data. Only the low 24 address bits reach the bus. They are presented as a 23-bit word address, and two byte strobes pick the byte lane inside the word.

Each bus cycle has three phases:
- The address and direction are set up for at least one clock.
- The address strobe and the byte strobes are asserted.
- The strobes are held until the acknowledge, after two-flop synchronisation, is seen low. Then all strobes are negated for at least one clock.

A long word runs as two word cycles, the high half first. An odd-address word or long-word request is refused with a one-clock alignment error, and no cycle starts. When the last cycle of a request completes, a one-clock done pulse is raised. For reads, the assembled read data is presented on the same clock.

Top module: `async_bus_master`

## Requirements
- R1: `bus_addr` equals bits 23..1 of the request address, and bits 31..24 have no effect. The second word address of a long word is the first plus 2, modulo 2^24, so 0xFFFFFE is followed by 0x000000.
- R2: `bus_addr` and `bus_rnw` already hold their cycle values one clock before `bus_as_n` falls, and they stay unchanged while `bus_as_n` is low.
- R3: `req_size` 00 means byte, 01 means word, and 10 or 11 means long word. A byte at an even address asserts only `bus_uds_n` (data bits 15..8). A byte at an odd address asserts only `bus_lds_n` (bits 7..0). Word and long-word cycles assert both.
- R4: A cycle holds its strobes low for as long as `bus_ack_n` is high; there is no fixed limit. `bus_as_n` rises on the third rising clock edge after `bus_ack_n` is first sampled low.
- R5: A long word makes two cycles: the high 16 bits at address A, then the low 16 bits at A+2. `bus_as_n` is high for at least one clock between any two cycles.
- R6: A word or long-word request at an odd address raises `align_err` for exactly one clock, on the clock after the request. No strobe is asserted and no `done` is given.
- R7: A byte read is zero-extended from the selected lane. A word read appears in `rdata[15:0]` with zeros above. A long read places the first word in `rdata[31:16]` and the second in `rdata[15:0]`.
- R8: A byte write drives the byte on both lanes of `bus_dout`. A word write drives `req_wdata[15:0]`. A long write drives `req_wdata[31:16]` first, then `req_wdata[15:0]`. `bus_doe` is high during write cycles and low during read cycles.
- R9: `done` is high for exactly one clock. That clock is the first one with the strobes negated after the final cycle, and `rdata` is valid during it.
- R10: Out of reset and when idle, all strobes are negated and `busy`, `done` and `align_err` are low. `req_valid` is ignored while `busy` is high.
- R11: A cycle does not assert its strobes until the synchronised acknowledge has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 1x long word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock completion pulse |
| align_err | output | 1 | One-clock misaligned-request pulse |
| rdata | output | 32 | Assembled read data |
| bus_addr | output | 23 | Word address (byte address bits 23..1) |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper byte strobe (bits 15..8), active low |
| bus_lds_n | output | 1 | Lower byte strobe (bits 7..0), active low |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
The bench builds the block with its defaults: a 24-bit address and a two-stage acknowledge synchroniser. With these values, the long-word wrap from 0xFFFFFE to 0x000000 can be reached, as can the exact three-edge delay from acknowledge to strobe release.

A behavioural slave answers each cycle after a programmable latency, between 0 and 25 clocks. It can also hold its acknowledge for several clocks after the strobe rises, which exercises the release wait. A monitor compares address stability and acknowledge timing on every clock.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RELEASE = 2'd3
  } bm_state_e;

  function automatic logic is_long(input logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/bm_ack_sync.sv
module bm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_async,
  output logic ack_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= ack_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign ack_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bm_lane_steer.sv
module bm_lane_steer
  import bm_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              a0,
  input  logic              second,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_hi,
  output logic              sel_lo,
  output logic [WORD_W-1:0] lane_out
);
  logic wide;

  always_comb begin
    wide   = (size != SZ_BYTE);
    sel_hi = wide | ~a0;
    sel_lo = wide | a0;
    if (!wide)
      lane_out = {wdata[7:0], wdata[7:0]};
    else if (is_long(size) && !second)
      lane_out = wdata[DATA_W-1:WORD_W];
    else
      lane_out = wdata[WORD_W-1:0];
  end
endmodule

// File: rtl/bm_read_pack.sv
module bm_read_pack
  import bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        size,
  input  logic              a0,
  input  logic              second,
  input  logic [WORD_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (cap_en) begin
      if (size == SZ_BYTE)
        rdata_d = {{(DATA_W-8){1'b0}}, (a0 ? din[7:0] : din[15:8])};
      else if (!is_long(size))
        rdata_d = {{(DATA_W-WORD_W){1'b0}}, din};
      else if (!second)
        rdata_d = {din, {WORD_W{1'b0}}};
      else
        rdata_d = {rdata_q[DATA_W-1:WORD_W], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && size == SZ_BYTE) |=> (rdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
  import bm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              align_err,
  output logic [31:0]       rdata,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rnw,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic              bus_ack_n
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  bm_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        size_q, size_d;
  logic              wr_q, wr_d;
  logic [31:0]       wdata_q, wdata_d;
  logic              second_q, second_d;
  logic              err_q, err_d;
  logic              ack_s_n;
  logic              misalign_in;
  logic              last_word;
  logic              cap_en;
  logic              sel_hi, sel_lo;
  logic              active;

  bm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_n_async (bus_ack_n),
    .ack_n_sync  (ack_s_n)
  );

  assign misalign_in = (req_size != SZ_BYTE) && req_addr[0];
  assign last_word   = !is_long(size_q) || second_q;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    size_d   = size_q;
    wr_d     = wr_q;
    wdata_d  = wdata_q;
    second_d = second_q;
    err_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misalign_in) begin
            err_d = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            addr_d   = req_addr[ADDR_W-1:0];
            size_d   = req_size;
            wr_d     = req_write;
            wdata_d  = req_wdata;
            second_d = 1'b0;
          end
        end
      end
      ST_SETUP: begin
        if (ack_s_n) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!ack_s_n) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!last_word) begin
          state_d  = ST_SETUP;
          second_d = 1'b1;
          addr_d   = addr_q + WORD_STEP;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      size_q   <= SZ_BYTE;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      size_q   <= size_d;
      wr_q     <= wr_d;
      wdata_q  <= wdata_d;
      second_q <= second_d;
      err_q    <= err_d;
    end
  end

  bm_lane_steer u_steer (
    .size     (size_q),
    .a0       (addr_q[0]),
    .second   (second_q),
    .wdata    (wdata_q),
    .sel_hi   (sel_hi),
    .sel_lo   (sel_lo),
    .lane_out (bus_dout)
  );

  assign cap_en = (state_q == ST_ACTIVE) && !ack_s_n && !wr_q;

  bm_read_pack u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .size   (size_q),
    .a0     (addr_q[0]),
    .second (second_q),
    .din    (bus_din),
    .rdata  (rdata)
  );

  assign active    = (state_q == ST_ACTIVE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_RELEASE) && last_word;
  assign align_err = err_q;
  assign bus_addr  = addr_q[ADDR_W-1:1];
  assign bus_as_n  = !active;
  assign bus_uds_n = !(active && sel_hi);
  assign bus_lds_n = !(active && sel_lo);
  assign bus_rnw   = busy ? !wr_q : 1'b1;
  assign bus_doe   = busy && wr_q;

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> ($stable(bus_addr) && $stable(bus_rnw)));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && size_q == SZ_BYTE) |-> ($countones({bus_uds_n, bus_lds_n}) == 1));

  assert_wait_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ack_s_n) |=> !bus_as_n);

  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |=> bus_as_n);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (bus_as_n && !done));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ack_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> ack_s_n);
endmodule

// File: tb/tb_async_bus_master.sv
module tb_async_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, align_err;
  logic [31:0] rdata;
  logic [22:0] bus_addr;
  logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rnw, bus_doe;
  logic [15:0] bus_dout, bus_din;
  logic        bus_ack_n = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] slv_data(input logic [22:0] wa);
    return {wa[7:0] ^ 8'h5A, wa[15:8] + 8'h13};
  endfunction

  assign bus_din = slv_data(bus_addr);

  async_bus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .align_err(align_err), .rdata(rdata),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_rnw(bus_rnw), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // slave and per-clock monitor
  int          lat = 0;
  int          hold = 0;
  int          lowcnt = 0;
  int          holdcnt = 0;
  int          ack_cyc = 0;
  int          rise_cyc = -1;
  logic        last_as = 1'b1;
  logic [22:0] last_addr = '0;
  logic [22:0] m_addr[$];
  logic        m_uds[$];
  logic        m_lds[$];
  logic        m_rnw[$];
  logic        m_doe[$];
  logic [15:0] m_dout[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bus_ack_n <= 1'b1;
      lowcnt = 0;
      holdcnt = 0;
      last_as = 1'b1;
    end else begin
      if (!bus_as_n && last_as) begin
        chk("R2", "address set up before strobe", {9'b0, bus_addr}, {9'b0, last_addr});
        chk("R11", "ack released at strobe start", {31'b0, bus_ack_n}, 32'd1);
        m_addr.push_back(bus_addr);
        m_uds.push_back(bus_uds_n);
        m_lds.push_back(bus_lds_n);
        m_rnw.push_back(bus_rnw);
        m_doe.push_back(bus_doe);
        m_dout.push_back(bus_dout);
      end
      if (!bus_as_n && !last_as)
        chk("R2", "address held during strobe", {9'b0, bus_addr}, {9'b0, last_addr});
      if (bus_as_n && !last_as) begin
        chk("R4", "ack to strobe release clocks", cyc - ack_cyc, 32'd3);
        rise_cyc = cyc;
      end
      if (!bus_as_n) begin
        holdcnt = 0;
        if (bus_ack_n && lowcnt == lat) begin
          bus_ack_n <= 1'b0;
          ack_cyc = cyc;
        end
        lowcnt++;
      end else begin
        lowcnt = 0;
        if (!bus_ack_n) begin
          if (holdcnt >= hold) bus_ack_n <= 1'b1;
          else holdcnt++;
        end
      end
      last_as = bus_as_n;
      last_addr = bus_addr;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input int l, input bit spoil);
    logic [23:0] a0, a1;
    logic [22:0] e_addr[2];
    logic [15:0] e_dout[2];
    logic [15:0] d0, d1;
    logic [31:0] e_rd;
    logic        e_uds, e_lds;
    int          n;
    bit          got;
    a0 = a[23:0];
    a1 = a0 + 24'd2;
    n = sz[1] ? 2 : 1;
    e_addr[0] = a0[23:1];
    e_addr[1] = a1[23:1];
    d0 = slv_data(e_addr[0]);
    d1 = slv_data(e_addr[1]);
    e_uds = (sz == 2'b00) && a0[0];
    e_lds = (sz == 2'b00) && !a0[0];
    if (sz == 2'b00) begin
      e_dout[0] = {wd[7:0], wd[7:0]};
      e_rd = a0[0] ? {24'b0, d0[7:0]} : {24'b0, d0[15:8]};
    end else if (!sz[1]) begin
      e_dout[0] = wd[15:0];
      e_rd = {16'b0, d0};
    end else begin
      e_dout[0] = wd[31:16];
      e_rd = {d0, d1};
    end
    e_dout[1] = wd[15:0];
    lat = l;
    m_addr.delete(); m_uds.delete(); m_lds.delete();
    m_rnw.delete(); m_doe.delete(); m_dout.delete();
    step();
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    step();
    req_valid = 1'b0;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin got = 1; break; end
      if (spoil && i == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b01; req_addr = 32'h0000_0400;
      end else begin
        req_valid = 1'b0;
      end
      step();
    end
    req_valid = 1'b0;
    chk("R9", "done seen", {31'b0, got}, 32'd1);
    if (got) begin
      chk("R9", "done on first negated clock", cyc, rise_cyc);
      chk("R5", "cycle count", m_addr.size(), n);
      for (int k = 0; k < n && k < m_addr.size(); k++) begin
        chk("R1", "word address", {9'b0, m_addr[k]}, {9'b0, e_addr[k]});
        chk("R3", "upper strobe", {31'b0, m_uds[k]}, {31'b0, e_uds});
        chk("R3", "lower strobe", {31'b0, m_lds[k]}, {31'b0, e_lds});
        chk("R2", "direction", {31'b0, m_rnw[k]}, {31'b0, !wr});
        chk("R8", "data enable", {31'b0, m_doe[k]}, {31'b0, wr});
        if (wr) chk("R8", "write lanes", {16'b0, m_dout[k]}, {16'b0, e_dout[k]});
      end
      if (!wr) chk("R7", "read data", rdata, e_rd);
      step();
      chk("R9", "done one clock", {31'b0, done}, 32'd0);
      chk("R10", "idle after request", {31'b0, busy}, 32'd0);
    end
  endtask

  task automatic do_err(input logic [1:0] sz, input logic [31:0] a);
    m_addr.delete();
    step();
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    step();
    req_valid = 1'b0;
    chk("R6", "alignment error raised", {31'b0, align_err}, 32'd1);
    step();
    chk("R6", "alignment error one clock", {31'b0, align_err}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      chk("R6", "no strobe after error", {31'b0, bus_as_n}, 32'd1);
      chk("R6", "no done after error", {31'b0, done}, 32'd0);
      step();
    end
    chk("R6", "no cycle recorded", m_addr.size(), 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R10", "reset address strobe", {31'b0, bus_as_n}, 32'd1);
    chk("R10", "reset upper strobe", {31'b0, bus_uds_n}, 32'd1);
    chk("R10", "reset lower strobe", {31'b0, bus_lds_n}, 32'd1);
    chk("R10", "reset busy", {31'b0, busy}, 32'd0);
    chk("R10", "reset done", {31'b0, done}, 32'd0);
    chk("R10", "reset align_err", {31'b0, align_err}, 32'd0);

    do_req(1'b0, 2'b00, 32'h0000_1234, '0, 0, 0);            // R3 R7 byte even
    do_req(1'b0, 2'b00, 32'h0000_1235, '0, 3, 0);            // R3 R7 byte odd
    do_req(1'b0, 2'b01, 32'h0012_3456, '0, 1, 0);            // R7 word
    do_req(1'b0, 2'b10, 32'h0001_0000, '0, 2, 0);            // R5 R7 long
    do_req(1'b1, 2'b00, 32'h0000_0040, 32'h0000_00C3, 0, 0); // R8 byte even
    do_req(1'b1, 2'b00, 32'h0000_0041, 32'h0000_007E, 2, 0); // R8 byte odd
    do_req(1'b1, 2'b01, 32'h0000_0800, 32'h0000_BEEF, 1, 0); // R8 word
    do_req(1'b1, 2'b10, 32'h0020_0010, 32'hCAFE_F00D, 4, 0); // R5 R8 long
    do_req(1'b0, 2'b10, 32'hAB_FFFFFE, '0, 0, 0);            // R1 wrap, high bits dropped
    do_req(1'b1, 2'b11, 32'h5500_0100, 32'h1357_9BDF, 0, 0); // R3 size 11 is long
    do_req(1'b0, 2'b01, 32'h0000_2000, '0, 25, 0);           // R4 long wait
    do_req(1'b0, 2'b10, 32'h0000_3000, '0, 5, 1);            // R10 request ignored while busy
    hold = 5;
    do_req(1'b0, 2'b10, 32'h0000_4000, '0, 0, 0);            // R11 ack held after strobe
    do_req(1'b1, 2'b01, 32'h0000_4100, 32'h0000_A5A5, 0, 0); // R11 back-to-back
    hold = 0;
    do_err(2'b01, 32'h0000_0101);                             // R6 word odd
    do_err(2'b10, 32'h0000_0203);                             // R6 long odd
    do_req(1'b0, 2'b00, 32'h0000_0007, '0, 1, 0);            // byte odd still allowed

    repeat (4) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule